// File: doc/BRIEF.md
# Instruction Fetch Line Cache

This block is a read-only instruction cache. It sits between the instruction-fetch port of a processor and a slow program memory that has wait states. The fetch side presents an address with a cacheable flag. It holds the request until the block raises ready, and then takes a 32-bit word.

The cache has 64 direct-mapped lines. Each line is 256 bits wide and is made of eight 32-bit segments. One segment may carry a single 32-bit instruction or two 16-bit instructions. The cache returns the whole segment and does not decode it.

A cacheable fetch that hits is answered in the same cycle. A miss reads the full line from memory, writes it into the array, and then answers. One extra line-wide buffer keeps a copy of the line used most recently, and fetches that match it are served from it. Non-cacheable fetches go to memory and leave the array untouched. A one-cycle flush input drops every line.

The memory side takes a one-cycle request carrying the line address. Some cycles later it answers with a one-cycle valid that carries the 256-bit line. The number of cycles in between is set by the memory, from 1 to 8.

Top module: `ifetch_line_cache`

## Requirements
- R1: After reset, `fetch_rdy` and `mem_req` are 0, and the first cacheable fetch of any address is a miss.
- R2: A cacheable fetch to a resident line raises `fetch_rdy` in the same cycle as `fetch_req` (0 wait cycles). The returned word is the segment chosen by address bits [4:2].
- R3: A cacheable miss issues `mem_req` in the cycle of the request, with `mem_line` equal to address bits [AW-1:5]. With a memory latency of L cycles, `fetch_rdy` rises after L+1 wait cycles.
- R4: Segment s (address bits [4:2] = s) returns bits [32*s+31 : 32*s] of the line read from memory, for every s from 0 to 7.
- R5: The mapping is direct. The line index is address bits [10:5] and the tag is bits [AW-1:11]. A line with the same index and a different tag evicts the resident one. Lines with different indices coexist.
- R6: A non-cacheable fetch always goes to memory (L+1 wait cycles) and returns the addressed segment. It allocates no line and leaves any resident line at the same index intact.
- R7: A one-cycle `flush` pulse invalidates every line and the line buffer. A fetch presented in the flush cycle is treated as a miss.
- R8: Each miss or non-cacheable fetch produces exactly one single-cycle `mem_req`. A hit produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all lines and the line buffer |
| fetch_req | input | 1 | Fetch request, held until `fetch_rdy` |
| fetch_addr | input | AW-2 | Byte address bits [AW-1:2] |
| fetch_cacheable | input | 1 | 1 = cacheable, 0 = bypass the array |
| fetch_rdy | output | 1 | Word on `fetch_word` is valid |
| fetch_word | output | 32 | Returned 32-bit segment |
| mem_req | output | 1 | One-cycle line read request |
| mem_line | output | AW-5 | Line address, byte address bits [AW-1:5] |
| mem_valid | input | 1 | Line data valid (one cycle) |
| mem_data | input | 256 | Line from memory, segment s in bits [32s+31:32s] |

## Verification
Three situations are the hardest to reach from the ports.

- **Fetch in the flush cycle.** The bench raises `flush` in the same cycle as a fetch to a line that is certainly resident. It then expects a full miss latency, and a miss on another line that was resident before.
- **Eviction.** The table walk fetches two addresses that share index bits [10:5] but differ in tag. It then refetches the first address and expects a miss. A line at a different index stays a hit throughout.
- **Non-cacheable fetch to a resident line.** The bench aims a non-cacheable fetch at a line that is resident and expects memory latency. A cacheable fetch of that line afterwards must still hit, which shows the bypass changed nothing.

// File: rtl/ifetch_line_cache.sv
module ifetch_line_cache #(
  parameter int AW    = 20,
  parameter int LINES = 64,
  parameter int SEGS  = 8,
  parameter int WW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      fetch_req,
  input  logic [AW-1:2]             fetch_addr,
  input  logic                      fetch_cacheable,
  output logic                      fetch_rdy,
  output logic [WW-1:0]             fetch_word,
  output logic                      mem_req,
  output logic [AW-1:$clog2(SEGS)+2] mem_line,
  input  logic                      mem_valid,
  input  logic [WW*SEGS-1:0]        mem_data
);
  localparam int SW  = $clog2(SEGS);
  localparam int OW  = SW + 2;
  localparam int IW  = $clog2(LINES);
  localparam int TW  = AW - OW - IW;
  localparam int LAW = AW - OW;
  localparam int LW  = WW * SEGS;

  typedef enum logic [1:0] {IDLE, WAIT, RESP} st_t;
  st_t st;

  logic [LW-1:0]  data_q [LINES];
  logic [TW-1:0]  tag_q  [LINES];
  logic [LINES-1:0] vld_q;

  logic           buf_v;
  logic [LAW-1:0] buf_la;
  logic [LW-1:0]  buf_d;

  logic [LAW-1:0] req_la_q;
  logic [SW-1:0]  req_seg_q;
  logic           req_nc_q;
  logic [WW-1:0]  resp_q;

  wire [LAW-1:0] laddr = fetch_addr[AW-1:OW];
  wire [IW-1:0]  idx   = fetch_addr[OW+IW-1:OW];
  wire [TW-1:0]  tag   = fetch_addr[AW-1:OW+IW];
  wire [SW-1:0]  seg   = fetch_addr[OW-1:2];

  wire arr_hit = vld_q[idx] && (tag_q[idx] == tag);
  wire buf_hit = buf_v && (buf_la == laddr);
  wire hit     = fetch_cacheable && !flush && (arr_hit || buf_hit);

  wire [LW-1:0] line_sel  = buf_hit ? buf_d : data_q[idx];
  wire [WW-1:0] hit_word  = line_sel[seg*WW +: WW];
  wire [WW-1:0] fill_word = mem_data[req_seg_q*WW +: WW];
  wire          fill      = (st == WAIT) && mem_valid && !req_nc_q;
  wire [IW-1:0] fill_idx  = req_la_q[IW-1:0];

  assign fetch_rdy  = (st == RESP) || ((st == IDLE) && fetch_req && hit);
  assign fetch_word = (st == RESP) ? resp_q : hit_word;
  assign mem_req    = (st == IDLE) && fetch_req && !hit;
  assign mem_line   = laddr;

  always_ff @(posedge clk) begin
    if (fill) begin
      data_q[fill_idx] <= mem_data;
      tag_q[fill_idx]  <= req_la_q[LAW-1:IW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      vld_q     <= '0;
      buf_v     <= 1'b0;
      buf_la    <= '0;
      buf_d     <= '0;
      req_la_q  <= '0;
      req_seg_q <= '0;
      req_nc_q  <= 1'b0;
      resp_q    <= '0;
    end else begin
      if (flush) begin
        vld_q <= '0;
        buf_v <= 1'b0;
      end
      case (st)
        IDLE: begin
          if (mem_req) begin
            st        <= WAIT;
            req_la_q  <= laddr;
            req_seg_q <= seg;
            req_nc_q  <= !fetch_cacheable;
          end else if (fetch_req && hit && !buf_hit) begin
            buf_v  <= 1'b1;
            buf_la <= laddr;
            buf_d  <= data_q[idx];
          end
        end
        WAIT: begin
          if (mem_valid) begin
            resp_q <= fill_word;
            st     <= RESP;
            if (!req_nc_q) begin
              vld_q[fill_idx] <= 1'b1;
              buf_v  <= 1'b1;
              buf_la <= req_la_q;
              buf_d  <= mem_data;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R8
  mreq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R3
  resp_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT) && mem_valid |=> fetch_rdy);

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !fill |=> (vld_q == '0) && !buf_v);

  // R6
  nc_noalloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT) && req_nc_q && !flush |=> $stable(vld_q));

  // R2
  rdy_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rdy && (st == IDLE) |-> fetch_req && !mem_req);
endmodule

// File: tb/sim_ifetch_line_cache.sv
module sim_ifetch_line_cache;
  localparam int AW  = 20;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic fetch_req = 1'b0;
  logic [AW-1:2] fetch_addr = '0;
  logic fetch_cacheable = 1'b0;
  logic fetch_rdy;
  logic [31:0] fetch_word;
  logic mem_req;
  logic [AW-1:5] mem_line;
  logic mem_valid;
  logic [255:0] mem_data;

  always #5 clk = ~clk;

  ifetch_line_cache #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_cacheable(fetch_cacheable),
    .fetch_rdy(fetch_rdy), .fetch_word(fetch_word),
    .mem_req(mem_req), .mem_line(mem_line), .mem_valid(mem_valid), .mem_data(mem_data)
  );

  function automatic logic [31:0] mword(input logic [14:0] l, input int s);
    return {4'(s), 13'h0, l};
  endfunction

  int cnt = 0;
  int nreq = 0;
  logic [14:0] lat_line = '0;
  always @(posedge clk) begin
    if (mem_req) begin
      cnt <= LAT;
      lat_line <= mem_line;
      nreq <= nreq + 1;
    end else if (cnt > 0) cnt <= cnt - 1;
  end
  assign mem_valid = (cnt == 1);
  always_comb
    for (int s = 0; s < 8; s++) mem_data[32*s +: 32] = mword(lat_line, s);

  int n_cmp = 0;
  int n_mis = 0;
  bit done = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic fetch(input logic c, input logic [AW-1:0] a, input bit fl,
                       output logic [31:0] d, output int waits, output int reqs);
    int n0;
    @(negedge clk);
    n0 = nreq;
    fetch_req = 1'b1; fetch_addr = a[AW-1:2]; fetch_cacheable = c; flush = fl;
    waits = 0;
    forever begin
      #4;
      if (fetch_rdy) break;
      waits++;
      @(negedge clk);
      flush = 1'b0;
      if (waits > 50) break;
    end
    d = fetch_word;
    @(negedge clk);
    flush = 1'b0;
    fetch_req = 1'b0;
    reqs = nreq - n0;
  endtask

  // {cacheable, byte address, expected waits, requirement number}
  localparam logic [28:0] VEC [12] = '{
    {1'b1, 20'h00040, 4'd4, 4'd1},  // R1 first fetch misses
    {1'b1, 20'h00044, 4'd0, 4'd2},  // R2 hit
    {1'b1, 20'h0005C, 4'd0, 4'd2},  // R2 hit segment 7
    {1'b1, 20'h00060, 4'd4, 4'd3},  // R3 miss, index 3
    {1'b1, 20'h00040, 4'd0, 4'd2},  // R2 hit from array
    {1'b1, 20'h00848, 4'd4, 4'd5},  // R5 same index 2, new tag
    {1'b1, 20'h00040, 4'd4, 4'd5},  // R5 evicted
    {1'b1, 20'h00060, 4'd0, 4'd5},  // R5 other index survives
    {1'b0, 20'h01000, 4'd4, 4'd6},  // R6 bypass
    {1'b1, 20'h01004, 4'd4, 4'd6},  // R6 no allocation
    {1'b0, 20'h00044, 4'd4, 4'd6},  // R6 bypass on resident line
    {1'b1, 20'h00048, 4'd0, 4'd6}   // R6 resident line untouched
  };

  initial begin
    logic [31:0] d;
    int w, rq;
    repeat (3) @(negedge clk);
    #4;
    chk("R1 rdy after reset", 32'(fetch_rdy), 0);
    chk("R1 mem_req after reset", 32'(mem_req), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      logic [AW-1:0] a;
      a = VEC[i][27:8];
      fetch(VEC[i][28], a, 0, d, w, rq);
      chk($sformatf("R%0d vec %0d waits", VEC[i][3:0], i), w, VEC[i][7:4]);
      chk($sformatf("R%0d vec %0d word", VEC[i][3:0], i), d, mword(a[19:5], int'(a[4:2])));
      // R8 one request per memory access, none on hit
      chk($sformatf("R8 vec %0d requests", i), rq, (VEC[i][7:4] != 0) ? 1 : 0);
    end

    // R4 segment sweep after one refill
    fetch(1, 20'h02000, 0, d, w, rq);
    chk("R3 sweep miss waits", w, LAT + 1);
    for (int s = 0; s < 8; s++) begin
      fetch(1, 20'h02000 + 20'(4*s), 0, d, w, rq);
      chk($sformatf("R4 seg %0d waits", s), w, 0);
      chk($sformatf("R4 seg %0d word", s), d, mword(15'h0100, s));
    end

    // R7 fetch in flush cycle to resident line misses
    fetch(1, 20'h02010, 1, d, w, rq);
    chk("R7 fetch during flush waits", w, LAT + 1);
    chk("R7 fetch during flush word", d, mword(15'h0100, 4));
    fetch(1, 20'h00060, 0, d, w, rq);
    chk("R7 other line flushed", w, LAT + 1);

    // R7 plain flush pulse then refetch
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    fetch(1, 20'h00064, 0, d, w, rq);
    chk("R7 after flush pulse waits", w, LAT + 1);
    fetch(1, 20'h00068, 0, d, w, rq);
    chk("R2 hit after refill waits", w, 0);
    chk("R2 hit after refill word", d, mword(15'h0003, 2));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end
endmodule